// File: doc/BRIEF.md
# x86 Effective Address Generator

This block turns a decoded ModRM byte into a memory operand address. The decoder presents the mod and r/m fields, the address size, a snapshot of the eight general registers, the two default segment bases and an optional override segment base, all together with a one-cycle `start`. The block then pulls the SIB byte, if the form needs one, and the displacement bytes from a byte stream with a valid/ready handshake. When it has every byte, it produces the effective offset and the 32-bit linear address, and marks them with a one-cycle `done`.

The block handles both the 16-bit form, which adds pairs of base and index registers, and the 32-bit form, which uses a single register or a SIB byte with a scaled index. It picks SS as the default segment for stack-based forms and DS for all other forms. Register-direct operands (mod=3) are not addresses. For these the block raises `err` and reads nothing from the stream. Inputs are sampled only on a `start` that arrives while the block is idle.

Top module: `ea_gen`

## Requirements
- R1: In 16-bit mode, r/m 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, using register indices EAX=0, ECX=1, EDX=2, EBX=3, ESP=4, EBP=5, ESI=6, EDI=7 of `gpr_i` (bits 32*i+31:32*i, low 16 bits used). mod=1 adds a sign-extended byte and mod=2 adds a 16-bit displacement. The sum wraps modulo 2^16 and `offset_o[31:16]` is zero.
- R2: In 16-bit mode, mod=0 with r/m=6 uses only a 16-bit displacement, with no register, and defaults to DS.
- R3: The default segment is SS when the base register is BP, EBP or ESP. Every other form, including the bare-displacement forms, uses DS.
- R4: In 32-bit mode without SIB, the offset is register[r/m], plus a sign-extended byte for mod=1 or a 32-bit displacement for mod=2. mod=0 with r/m=5 is a bare 32-bit displacement with DS.
- R5: In 32-bit mode, r/m=4 brings a SIB byte. SIB[2:0] is the base register and SIB[5:3] the index register, which is shifted left by SIB[7:6]. An index of 4 adds zero.
- R6: When the SIB base is 5, mod=0 replaces the base with a 32-bit displacement and uses DS. mod=1 or mod=2 uses EBP with SS and then adds the usual displacement.
- R7: When `seg_ovr_i` is set, `ovr_base_i` replaces the default segment base in the linear address. The offset does not change.
- R8: Stream bytes are taken in this order: the SIB byte first, then the displacement least significant byte first. The number of bytes is exactly what the form needs: 0, 1, 2 or 4 for the displacement, plus one for the SIB byte.
- R9: `bs_ready` is high only while a byte is still owed. Bytes offered at any other time are ignored and do not affect the result.
- R10: mod=3 raises `err` for one cycle, one cycle after `start`. It consumes no byte and produces no `done`.
- R11: `linear_o` = segment base + offset, modulo 2^32. In 16-bit mode the offset is zero-extended before the add.
- R12: `done` is a one-cycle pulse. It arrives two clock edges after the last byte is accepted, or two edges after `start` when no byte is needed. `offset_o` and `linear_o` are valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new address; samples all request inputs when idle |
| mod_i | input | 2 | ModRM mod field |
| rm_i | input | 3 | ModRM r/m field |
| addr32_i | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| gpr_i | input | 256 | Register snapshot, register i at bits 32*i+31:32*i |
| ds_base_i | input | 32 | DS segment base |
| ss_base_i | input | 32 | SS segment base |
| seg_ovr_i | input | 1 | Segment override present |
| ovr_base_i | input | 32 | Override segment base |
| bs_valid | input | 1 | Stream byte valid |
| bs_data | input | 8 | Stream byte |
| bs_ready | output | 1 | Block accepts a stream byte |
| done | output | 1 | Result valid pulse |
| err | output | 1 | mod=3 presented |
| offset_o | output | 32 | Effective offset |
| linear_o | output | 32 | Linear address |

## Verification
The bench targets the forms that break the regular pattern. These are the 16-bit mod=0 r/m=6 and 32-bit mod=0 r/m=5 bare displacements, and the SIB byte whose base field is 5, where mod decides between a displacement with DS and EBP with SS. A wrong decode there gives the wrong byte count, so the stream hangs or leftover bytes are consumed, and the address also comes out wrong. Other targets are the SIB index of 4, which adds ESP if it is missed, and negative 8-bit displacements, which are off by 256 if zero-extended. It also checks 16-bit sums that overflow, where a missing wrap leaks into bit 16, and a linear address that wraps past 2^32. The bench stalls the stream and offers junk bytes while `bs_ready` is low, so a design that takes a byte early or reorders bytes gives a wrong result.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int AW       = 32;
    localparam int NGPR     = 8;
    localparam int BYTE_W   = 8;
    localparam int DISP_MAX = AW / BYTE_W;
    localparam int DCNT_W   = $clog2(DISP_MAX + 1);
    localparam int HALF_W   = AW / 2;

    localparam logic [2:0] RX_BX = 3'd3;
    localparam logic [2:0] RX_SP = 3'd4;
    localparam logic [2:0] RX_BP = 3'd5;
    localparam logic [2:0] RX_SI = 3'd6;
    localparam logic [2:0] RX_DI = 3'd7;

    typedef enum logic [1:0] {F_IDLE, F_SIB, F_DISP, F_CALC} fstate_e;

    typedef struct packed {
        logic [1:0] md;
        logic [2:0] rm;
        logic       a32;
    } form_t;

    typedef struct packed {
        logic [AW-1:0] off;
        logic          use_ss;
    } ea_res_t;

    typedef logic [NGPR-1:0][AW-1:0] gpr_t;

    function automatic logic form_has_sib(form_t f);
        return f.a32 && (f.md != 2'd3) && (f.rm == 3'd4);
    endfunction

    // number of displacement bytes owed by a form (sib_base only matters after SIB)
    function automatic logic [DCNT_W-1:0] disp_bytes(form_t f, logic [2:0] sib_base);
        logic [DCNT_W-1:0] n;
        n = '0;
        case (f.md)
            2'd1: n = DCNT_W'(1);
            2'd2: n = f.a32 ? DCNT_W'(DISP_MAX) : DCNT_W'(2);
            2'd0: begin
                if (f.a32) begin
                    if (f.rm == 3'd5 || (f.rm == 3'd4 && sib_base == 3'd5))
                        n = DCNT_W'(DISP_MAX);
                end else if (f.rm == 3'd6) begin
                    n = DCNT_W'(2);
                end
            end
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic logic [AW-1:0] sext_disp(logic [AW-1:0] raw, logic [DCNT_W-1:0] n);
        logic [AW-1:0] r;
        case (n)
            DCNT_W'(1): r = {{(AW-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
            DCNT_W'(2): r = {{(AW-2*BYTE_W){raw[2*BYTE_W-1]}}, raw[2*BYTE_W-1:0]};
            default:    r = raw;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ea_fetch.sv
module ea_fetch
    import ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  form_t                form_i,
    input  logic                 byte_valid,
    input  logic [BYTE_W-1:0]    byte_data,
    output logic                 byte_ready,
    output logic                 idle,
    output logic                 calc,
    output logic                 err_o,
    output form_t                form_q,
    output logic [BYTE_W-1:0]    sib_q,
    output logic [AW-1:0]        disp_q,
    output logic [DCNT_W-1:0]    dlen_q
);
    fstate_e           state;
    logic [DCNT_W-1:0] cnt;
    logic              fire;
    logic [DCNT_W-1:0] first_len;
    logic [DCNT_W-1:0] sib_len;

    assign byte_ready = (state == F_SIB) || (state == F_DISP);
    assign fire       = byte_ready && byte_valid;
    assign idle       = (state == F_IDLE);
    assign calc       = (state == F_CALC);
    assign first_len  = disp_bytes(form_i, 3'd0);
    assign sib_len    = disp_bytes(form_q, byte_data[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= F_IDLE;
            err_o  <= 1'b0;
            form_q <= '0;
            sib_q  <= '0;
            disp_q <= '0;
            dlen_q <= '0;
            cnt    <= '0;
        end else begin
            err_o <= 1'b0;
            case (state)
                F_IDLE: begin
                    if (start) begin
                        form_q <= form_i;
                        sib_q  <= '0;
                        disp_q <= '0;
                        cnt    <= '0;
                        dlen_q <= '0;
                        if (form_i.md == 2'd3) begin
                            err_o <= 1'b1;
                        end else if (form_has_sib(form_i)) begin
                            state <= F_SIB;
                        end else begin
                            dlen_q <= first_len;
                            state  <= (first_len != '0) ? F_DISP : F_CALC;
                        end
                    end
                end
                F_SIB: begin
                    if (fire) begin
                        sib_q  <= byte_data;
                        dlen_q <= sib_len;
                        state  <= (sib_len != '0) ? F_DISP : F_CALC;
                    end
                end
                F_DISP: begin
                    if (fire) begin
                        for (int b = 0; b < DISP_MAX; b++) begin
                            if (cnt == DCNT_W'(b))
                                disp_q[BYTE_W*b +: BYTE_W] <= byte_data;
                        end
                        cnt <= cnt + 1'b1;
                        if (DCNT_W'(cnt + 1'b1) == dlen_q)
                            state <= F_CALC;
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    // R8
    sib_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state == F_SIB && byte_valid) |=> (sib_q == $past(byte_data) && state != F_SIB));

    // R9
    calc_release_chk: assert property (@(posedge clk) disable iff (rst)
        calc |=> (idle && !byte_ready));

    // R10
    err_stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (idle && !byte_ready));
endmodule

// File: rtl/ea_off16.sv
module ea_off16
    import ea_pkg::*;
(
    input  form_t         form_i,
    input  gpr_t          gpr_i,
    input  logic [AW-1:0] disp_i,
    output ea_res_t       res_o
);
    logic [HALF_W-1:0] base_v;
    logic [HALF_W-1:0] idx_v;
    logic [HALF_W-1:0] sum_v;
    logic              ss_v;

    always_comb begin
        base_v = '0;
        idx_v  = '0;
        ss_v   = 1'b0;
        case (form_i.rm)
            3'd0: begin base_v = gpr_i[RX_BX][HALF_W-1:0]; idx_v = gpr_i[RX_SI][HALF_W-1:0]; end
            3'd1: begin base_v = gpr_i[RX_BX][HALF_W-1:0]; idx_v = gpr_i[RX_DI][HALF_W-1:0]; end
            3'd2: begin base_v = gpr_i[RX_BP][HALF_W-1:0]; idx_v = gpr_i[RX_SI][HALF_W-1:0]; ss_v = 1'b1; end
            3'd3: begin base_v = gpr_i[RX_BP][HALF_W-1:0]; idx_v = gpr_i[RX_DI][HALF_W-1:0]; ss_v = 1'b1; end
            3'd4: idx_v = gpr_i[RX_SI][HALF_W-1:0];
            3'd5: idx_v = gpr_i[RX_DI][HALF_W-1:0];
            3'd6: begin
                if (form_i.md != 2'd0) begin
                    base_v = gpr_i[RX_BP][HALF_W-1:0];
                    ss_v   = 1'b1;
                end
            end
            default: base_v = gpr_i[RX_BX][HALF_W-1:0];
        endcase
        sum_v = base_v + idx_v + disp_i[HALF_W-1:0];
    end

    assign res_o.off    = {{(AW-HALF_W){1'b0}}, sum_v};
    assign res_o.use_ss = ss_v;
endmodule

// File: rtl/ea_off32.sv
module ea_off32
    import ea_pkg::*;
(
    input  form_t               form_i,
    input  logic [BYTE_W-1:0]   sib_i,
    input  gpr_t                gpr_i,
    input  logic [AW-1:0]       disp_i,
    output ea_res_t             res_o
);
    logic [2:0]    sb, si;
    logic [1:0]    sc;
    logic [AW-1:0] base_v;
    logic [AW-1:0] idx_v;
    logic          ss_v;

    assign sb = sib_i[2:0];
    assign si = sib_i[5:3];
    assign sc = sib_i[7:6];

    always_comb begin
        base_v = '0;
        idx_v  = '0;
        ss_v   = 1'b0;
        if (form_i.rm == 3'd4) begin
            if (!(sb == RX_BP && form_i.md == 2'd0))
                base_v = gpr_i[sb];
            ss_v = (sb == RX_SP) || (sb == RX_BP && form_i.md != 2'd0);
            if (si != RX_SP)
                idx_v = gpr_i[si] << sc;
        end else begin
            if (!(form_i.rm == RX_BP && form_i.md == 2'd0))
                base_v = gpr_i[form_i.rm];
            ss_v = (form_i.rm == RX_BP) && (form_i.md != 2'd0);
        end
    end

    assign res_o.off    = base_v + idx_v + disp_i;
    assign res_o.use_ss = ss_v;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           mod_i,
    input  logic [2:0]           rm_i,
    input  logic                 addr32_i,
    input  logic [NGPR*AW-1:0]   gpr_i,
    input  logic [AW-1:0]        ds_base_i,
    input  logic [AW-1:0]        ss_base_i,
    input  logic                 seg_ovr_i,
    input  logic [AW-1:0]        ovr_base_i,
    input  logic                 bs_valid,
    input  logic [BYTE_W-1:0]    bs_data,
    output logic                 bs_ready,
    output logic                 done,
    output logic                 err,
    output logic [AW-1:0]        offset_o,
    output logic [AW-1:0]        linear_o
);
    form_t             form_in, form_q;
    gpr_t              gpr_q;
    logic [AW-1:0]     ds_q, ss_q, ob_q;
    logic              ovr_q;
    logic              f_idle, f_calc;
    logic [BYTE_W-1:0] sib_q;
    logic [AW-1:0]     disp_raw, disp_ext;
    logic [DCNT_W-1:0] dlen_q;
    ea_res_t           r16, r32, rsel;
    logic [AW-1:0]     seg_sel;

    assign form_in = '{md: mod_i, rm: rm_i, a32: addr32_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            gpr_q <= '0;
            ds_q  <= '0;
            ss_q  <= '0;
            ob_q  <= '0;
            ovr_q <= 1'b0;
        end else if (start && f_idle) begin
            gpr_q <= gpr_i;
            ds_q  <= ds_base_i;
            ss_q  <= ss_base_i;
            ob_q  <= ovr_base_i;
            ovr_q <= seg_ovr_i;
        end
    end

    ea_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .form_i     (form_in),
        .byte_valid (bs_valid),
        .byte_data  (bs_data),
        .byte_ready (bs_ready),
        .idle       (f_idle),
        .calc       (f_calc),
        .err_o      (err),
        .form_q     (form_q),
        .sib_q      (sib_q),
        .disp_q     (disp_raw),
        .dlen_q     (dlen_q)
    );

    assign disp_ext = sext_disp(disp_raw, dlen_q);

    ea_off16 u_off16 (
        .form_i (form_q),
        .gpr_i  (gpr_q),
        .disp_i (disp_ext),
        .res_o  (r16)
    );

    ea_off32 u_off32 (
        .form_i (form_q),
        .sib_i  (sib_q),
        .gpr_i  (gpr_q),
        .disp_i (disp_ext),
        .res_o  (r32)
    );

    assign rsel    = form_q.a32 ? r32 : r16;
    assign seg_sel = ovr_q ? ob_q : (rsel.use_ss ? ss_q : ds_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            offset_o <= '0;
            linear_o <= '0;
        end else begin
            done <= f_calc;
            if (f_calc) begin
                offset_o <= rsel.off;
                linear_o <= seg_sel + rsel.off;
            end
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    err_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !done);

    // R1
    wrap16_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !form_q.a32) |-> (offset_o[AW-1:HALF_W] == '0));

    // R7
    ovr_base_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ovr_q) |-> (linear_o == ob_q + offset_o));

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bs_ready);
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   mod_i = '0;
    logic [2:0]   rm_i = '0;
    logic         addr32_i = 1'b0;
    logic [255:0] gpr_i;
    logic [31:0]  ds_base_i = 32'h0002_0000;
    logic [31:0]  ss_base_i = 32'h0003_0000;
    logic         seg_ovr_i = 1'b0;
    logic [31:0]  ovr_base_i = 32'hFFFF_FF00;
    logic         bs_valid = 1'b0;
    logic [7:0]   bs_data = '0;
    logic         bs_ready, done, err;
    logic [31:0]  offset_o, linear_o;

    int unsigned regs [8];
    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ea_gen u0 (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: offset, segment choice and the byte list
    task automatic run(input int md, input int rm, input bit a32, input int sib,
                       input int unsigned dv, input bit ovr, input bit stall, input string tag);
        byte unsigned q[$];
        int unsigned off, base, idx, d, seg;
        bit ss;
        int dl;
        int k;
        int sb, si, sc;
        off = 0; base = 0; idx = 0; ss = 0; dl = 0; d = 0;
        sb = sib & 7; si = (sib >> 3) & 7; sc = (sib >> 6) & 3;
        if (md == 3) dl = 0;
        else if (!a32) begin
            dl = (md == 1) ? 1 : (md == 2) ? 2 : (rm == 6) ? 2 : 0;
            case (rm)
                0: base = regs[3] + regs[6];
                1: base = regs[3] + regs[7];
                2: begin base = regs[5] + regs[6]; ss = 1; end
                3: begin base = regs[5] + regs[7]; ss = 1; end
                4: base = regs[6];
                5: base = regs[7];
                6: if (md != 0) begin base = regs[5]; ss = 1; end
                default: base = regs[3];
            endcase
        end else begin
            if (rm == 4) begin
                q.push_back(byte'(sib));
                if (sb == 5 && md == 0) begin base = 0; dl = 4; end
                else begin base = regs[sb]; ss = (sb == 4) || (sb == 5); end
                if (si != 4) idx = regs[si] * (1 << sc);
            end else if (rm == 5 && md == 0) begin
                dl = 4;
            end else begin
                base = regs[rm]; ss = (rm == 5);
            end
            if (md == 1) dl = 1;
            if (md == 2) dl = 4;
        end
        for (int b = 0; b < dl; b++) q.push_back(byte'(dv >> (8 * b)));
        if (dl == 1) d = (dv & 32'h80) != 0 ? (dv | 32'hFFFF_FF00) : (dv & 32'hFF);
        else if (dl == 2) d = (dv & 32'h8000) != 0 ? (dv | 32'hFFFF_0000) : (dv & 32'hFFFF);
        else d = dv;
        off = base + idx + d;
        if (!a32) off = off & 32'hFFFF;
        seg = ovr ? ovr_base_i : (ss ? ss_base_i : ds_base_i);

        @(negedge clk);
        mod_i = 2'(md); rm_i = 3'(rm); addr32_i = a32; seg_ovr_i = ovr;
        start = 1'b1;
        bs_valid = 1'b1; bs_data = 8'hEE;  // junk offered while not ready (R9)
        @(negedge clk);
        start = 1'b0;
        mod_i = 2'd3; rm_i = 3'd1;         // changing inputs after start must not matter
        if (md == 3) begin
            check(err == 1'b1, {tag, " R10 err"}, err, 1);
            check(bs_ready == 1'b0, {tag, " R10 ready"}, bs_ready, 0);
            @(negedge clk);
            check(err == 1'b0 && done == 1'b0, {tag, " R10 quiet"}, {err, done}, 0);
            check(bs_ready == 1'b0, {tag, " R10 no consume"}, bs_ready, 0);
            bs_valid = 1'b0;
            return;
        end
        k = 0;
        forever begin
            check(bs_ready == (q.size() > 0), {tag, " R9/R8 ready"}, bs_ready, q.size() > 0);
            check(done == 1'b0, {tag, " R12 early done"}, done, 0);
            check(err == 1'b0, {tag, " R10 spurious err"}, err, 0);
            if (q.size() == 0) break;
            bs_valid = !(stall && (k % 2 == 0));
            bs_data  = bs_valid ? q[0] : 8'h5A;
            @(posedge clk);
            if (bs_valid && bs_ready) void'(q.pop_front());
            k++;
            @(negedge clk);
        end
        bs_valid = 1'b1; bs_data = 8'hC3;
        @(negedge clk);
        check(done == 1'b1, {tag, " R12 done"}, done, 1);
        check(offset_o == off, {tag, " R1-R6 offset"}, offset_o, off);
        check(linear_o == seg + off, {tag, " R11/R7/R3 linear"}, linear_o, seg + off);
        check(bs_ready == 1'b0, {tag, " R9 ready after done"}, bs_ready, 0);
        @(negedge clk);
        check(done == 1'b0, {tag, " R12 pulse"}, done, 0);
        bs_valid = 1'b0;
    endtask

    initial begin
        regs[0] = 32'h1122_3344; regs[1] = 32'h0000_1000;
        regs[2] = 32'hFFFF_FFF0; regs[3] = 32'h0000_F0F0;
        regs[4] = 32'h0001_0004; regs[5] = 32'h8000_7FFE;
        regs[6] = 32'h0000_0102; regs[7] = 32'h0000_FFFF;
        for (int i = 0; i < 8; i++) gpr_i[32*i +: 32] = regs[i];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 0 && err == 0 && bs_ready == 0, "reset state", {done, err, bs_ready}, 0);
        check(offset_o == 0 && linear_o == 0, "reset outputs", offset_o, 0);

        run(0, 0, 0, 0, 0,            0, 0, "R1 bx+si");
        run(0, 6, 0, 0, 32'h1234,     0, 0, "R2 bare d16");
        run(1, 2, 0, 0, 32'h80,       0, 0, "R3 bp+si-128");
        run(2, 7, 0, 0, 32'hFFFF,     0, 1, "R1 bx wrap");
        run(1, 6, 0, 0, 32'h05,       0, 0, "R3 bp+d8");
        run(2, 5, 0, 0, 32'h0001,     0, 0, "R1 di wrap");
        run(0, 5, 1, 0, 32'hDEADBEEF, 0, 0, "R4 bare d32");
        run(1, 1, 1, 0, 32'hF0,       0, 0, "R4 ecx-16");
        run(2, 5, 1, 0, 32'h0102_0304, 0, 1, "R3 ebp+d32");
        run(0, 4, 1, 8'hB0, 0,        0, 0, "R5 eax+esi*4");
        run(0, 4, 1, 8'hE4, 0,        0, 0, "R5 esp noidx");
        run(0, 4, 1, 8'h4D, 32'h1234, 0, 0, "R6 sib d32");
        run(1, 4, 1, 8'h3D, 32'h7F,   0, 1, "R6 sib ebp");
        run(2, 4, 1, 8'hD3, 32'h8000_0001, 0, 1, "R5 ebx+edx*8");
        run(1, 2, 0, 0, 32'h10,       1, 0, "R7 ovr 16");
        run(2, 0, 1, 0, 32'h0000_0200, 1, 0, "R11 ovr wrap");
        run(3, 0, 1, 0, 0,            0, 0, "R10 mod3");
        run(0, 7, 1, 0, 0,            0, 0, "R4 edi");
        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule